// File: doc/BRIEF.md
# Level-Prioritized Interrupt Controller

This block gathers thirteen interrupt request lines, numbered 1 to 13, into a pending register. A pending bit follows its line with one register stage. A mask register removes any line from consideration. Among the remaining lines, the source with the greatest 5-bit priority field in its own control register wins. The upper three bits of that field become the interrupt level shown to the processor. With the level comes an 8-bit vector. Sources that are serial-port channels supply the vector from their own programmable register. Every other source supplies an autovector, which is 24 plus the level.

Software reaches the registers through a single-cycle port. The port has a write strobe, a 6-bit address, 16-bit write data and combinational read data. Address map:
- 0x00: pending register, read-only. Bit n belongs to source n.
- 0x01: mask register.
- 0x10+n: control register of source n.
- 0x20+n: vector register of source n.

Level and vector leave the block through registers. Processor acknowledge cycles and nesting of levels belong to other logic.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Pending bit n (1..13, read at address 0x00) takes the value of `irq_i[n]` at each clock edge, so it is set while the line is high and clear once it is low.
- R2: `irq_i[0]` and pending bit 0 play no part. Bit 0 of the pending register always reads 0, and a high `irq_i[0]` never raises a level.
- R3: A 1 in bit n of the mask register (address 0x01) keeps source n out of arbitration. A pending and unmasked source is active.
- R4: The winner is the active source with the largest control bits [4:0]. A source whose field is 0 never wins.
- R5: When several active sources have the same largest field, the lowest-numbered source wins.
- R6: `irq_level_o` equals bits [4:2] of the winner's control register.
- R7: With no winner, `irq_level_o` and `irq_vector_o` are both 0.
- R8: When sources 12 or 13 win, the vector is their vector register (address 0x2C or 0x2D). When any other source wins, the vector is 24 plus the level.
- R9: A change of pending, mask or control state reaches the outputs one clock edge after the state register itself changes.
- R10: After reset the mask register reads 0xFFFF, control registers read 0, the vector registers of sources 12 and 13 read 0x0F, and the vector addresses of other sources read 0.
- R11: Control bits [7:5] are stored but have no effect on arbitration or level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request lines, bit n for source n; bit 0 unused |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_level_o | output | 3 | Interrupt level to the processor, 0 = none |
| irq_vector_o | output | 8 | Interrupt vector for the current level |

## Verification
The properties assume that `irq_i` is already synchronous to `clk_i` and free of unknowns. They also assume that each write lasts exactly one cycle of `reg_we_i`. They compare outputs against the previous cycle's pending, mask and winner state, so they rely on that state being settled by the clock edge. The stimulus drives every request line and every register access on the falling edge only. It holds the write strobe for a single cycle and drives all sixteen request bits to known values each cycle, including bit 0. Random writes also reach the control and vector addresses of sources that do not exist.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned NUM_SRC = 13;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned IDX_W   = $clog2(REG_W);
  localparam int unsigned ADDR_W  = IDX_W + 2;
  localparam int unsigned PRI_W   = 5;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned VEC_W   = 8;

  localparam logic [ADDR_W-1:0] ADDR_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(1);
  localparam logic [1:0]        PAGE_CTRL = 2'b01;
  localparam logic [1:0]        PAGE_VEC  = 2'b10;

  localparam logic [VEC_W-1:0]  AUTOVEC_BASE = VEC_W'(24);
  localparam logic [VEC_W-1:0]  VEC_RST      = VEC_W'(8'h0F);
endpackage

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int unsigned      N        = NUM_SRC,
  parameter logic [REG_W-1:0] UART_SRC = 16'h3000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [REG_W-1:0]              irq_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              pend_o,
  output logic [REG_W-1:0]              mask_o,
  output logic [REG_W-1:0][CTRL_W-1:0]  ctrl_o,
  output logic [REG_W-1:0][VEC_W-1:0]   vec_o,
  output logic [REG_W-1:0]              rdata_o
);
  localparam logic [REG_W-1:0] SRC_BITS = REG_W'((64'd1 << (N + 1)) - 64'd2);

  logic [REG_W-1:0]             pend_q, mask_q;
  logic [REG_W-1:0][CTRL_W-1:0] ctrl_q;
  logic [REG_W-1:0][VEC_W-1:0]  vec_q;
  logic [1:0]                   page;
  logic [IDX_W-1:0]             idx;

  assign page = addr_i[ADDR_W-1:IDX_W];
  assign idx  = addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
      ctrl_q <= '0;
      for (int n = 0; n < REG_W; n++) vec_q[n] <= UART_SRC[n] ? VEC_RST : '0;
    end else begin
      pend_q <= irq_i & SRC_BITS;
      if (we_i) begin
        if (addr_i == ADDR_MASK) mask_q <= wdata_i;
        for (int n = 1; n <= int'(N); n++) begin
          if (page == PAGE_CTRL && idx == IDX_W'(n))
            ctrl_q[n] <= wdata_i[CTRL_W-1:0];
          if (UART_SRC[n] && page == PAGE_VEC && idx == IDX_W'(n))
            vec_q[n] <= wdata_i[VEC_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_PEND)     rdata_o = pend_q;
    else if (addr_i == ADDR_MASK) rdata_o = mask_q;
    else if (page == PAGE_CTRL)  rdata_o = REG_W'(ctrl_q[idx]);
    else if (page == PAGE_VEC)   rdata_o = REG_W'(vec_q[idx]);
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [REG_W-1:0]              act_i,
  input  logic [REG_W-1:0][CTRL_W-1:0]  ctrl_i,
  output logic                          win_vld_o,
  output logic [IDX_W-1:0]              win_idx_o
);
  logic [PRI_W-1:0] best;

  // strict compare: a later source only replaces on a larger field
  always_comb begin
    best      = '0;
    win_vld_o = 1'b0;
    win_idx_o = '0;
    for (int n = 1; n <= int'(N); n++) begin
      if (act_i[n] && ctrl_i[n][PRI_W-1:0] > best) begin
        best      = ctrl_i[n][PRI_W-1:0];
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/lvl_irq_out.sv
module lvl_irq_out
  import lvl_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] UART_SRC = 16'h3000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          win_vld_i,
  input  logic [IDX_W-1:0]              win_idx_i,
  input  logic [REG_W-1:0][CTRL_W-1:0]  ctrl_i,
  input  logic [REG_W-1:0][VEC_W-1:0]   vec_i,
  output logic [LVL_W-1:0]              level_o,
  output logic [VEC_W-1:0]              vector_o
);
  logic [CTRL_W-1:0] sel_ctrl;
  logic [LVL_W-1:0]  lvl_d;
  logic [VEC_W-1:0]  vec_d;

  assign sel_ctrl = ctrl_i[win_idx_i];

  always_comb begin
    lvl_d = '0;
    vec_d = '0;
    if (win_vld_i) begin
      lvl_d = sel_ctrl[PRI_W-1:PRI_W-LVL_W];
      vec_d = UART_SRC[win_idx_i] ? vec_i[win_idx_i] : AUTOVEC_BASE + VEC_W'(lvl_d);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o  <= '0;
      vector_o <= '0;
    end else begin
      level_o  <= lvl_d;
      vector_o <= vec_d;
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned      N        = NUM_SRC,
  parameter logic [REG_W-1:0] UART_SRC = 16'h3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       irq_i,
  input  logic              reg_we_i,
  input  logic [5:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic [2:0]        irq_level_o,
  output logic [7:0]        irq_vector_o
);
  logic [REG_W-1:0]             pend, mask, act;
  logic [REG_W-1:0][CTRL_W-1:0] ctrl;
  logic [REG_W-1:0][VEC_W-1:0]  vec;
  logic                         win_vld;
  logic [IDX_W-1:0]             win_idx;

  lvl_irq_regs #(.N(N), .UART_SRC(UART_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .pend_o  (pend),
    .mask_o  (mask),
    .ctrl_o  (ctrl),
    .vec_o   (vec),
    .rdata_o (reg_rdata_o)
  );

  assign act = pend & ~mask;

  lvl_irq_arb #(.N(N)) u_arb (
    .act_i     (act),
    .ctrl_i    (ctrl),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx)
  );

  lvl_irq_out #(.UART_SRC(UART_SRC)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_vld_i (win_vld),
    .win_idx_i (win_idx),
    .ctrl_i    (ctrl),
    .vec_i     (vec),
    .level_o   (irq_level_o),
    .vector_o  (irq_vector_o)
  );
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
  import lvl_irq_pkg::*;
#(
  parameter int unsigned      N        = NUM_SRC,
  parameter logic [REG_W-1:0] UART_SRC = 16'h3000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       irq_i,
  input logic              reg_we_i,
  input logic [5:0]        reg_addr_i,
  input logic [15:0]       reg_wdata_i,
  input logic [2:0]        irq_level_o,
  input logic [7:0]        irq_vector_o,
  input logic [REG_W-1:0]  pend,
  input logic [REG_W-1:0]  mask
);
  localparam logic [REG_W-1:0] SRC_BITS = REG_W'((64'd1 << (N + 1)) - 64'd2);

  logic             past_ok;
  logic [REG_W-1:0] act;

  assign act = pend & ~mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  pend_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> pend == ($past(irq_i) & SRC_BITS));

  // R7
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(act) == '0) |-> (irq_level_o == '0 && irq_vector_o == '0));

  // R6
  level_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_level_o != '0) |-> $past(act) != '0);

  // R8
  autovec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_level_o != '0 && $past((act & UART_SRC) == '0))
      |-> irq_vector_o == AUTOVEC_BASE + VEC_W'(irq_level_o));

  // R3
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(reg_we_i && reg_addr_i == ADDR_MASK)) |-> mask == $past(reg_wdata_i));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.N(N), .UART_SRC(UART_SRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_i        (irq_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .irq_level_o  (irq_level_o),
  .irq_vector_o (irq_vector_o),
  .pend         (pend),
  .mask         (mask)
);

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_i = '0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [2:0]  irq_level_o;
  logic [7:0]  irq_vector_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0]       c_pend, p_pend, c_mask, p_mask, cur_irq;
  logic [15:0][7:0]  c_ctrl, p_ctrl, c_vec, p_vec;

  lvl_irq_ctrl uut (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [15:0] ref_out(input logic [15:0] pend, input logic [15:0] mask,
                                          input logic [15:0][7:0] ctrl, input logic [15:0][7:0] vec);
    logic [15:0] act;
    logic [4:0]  best;
    int          win;
    logic [2:0]  lvl;
    act  = pend & ~mask & 16'h3FFE;
    best = 0;
    win  = 0;
    for (int n = 1; n <= 13; n++)
      if (act[n] && ctrl[n][4:0] > best) begin best = ctrl[n][4:0]; win = n; end
    if (win == 0) return 16'h0;
    lvl = ctrl[win][4:2];
    if (win == 12 || win == 13) return {5'b0, lvl, vec[win]};
    return {5'b0, lvl, 8'd24 + {5'b0, lvl}};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] irq, input bit we, input logic [5:0] a, input logic [15:0] d);
    int n;
    @(negedge clk_i);
    chk("R9 R4 R5 R6 R8 model", {5'b0, irq_level_o, irq_vector_o}, ref_out(p_pend, p_mask, p_ctrl, p_vec));
    p_pend = c_pend; p_mask = c_mask; p_ctrl = c_ctrl; p_vec = c_vec;
    cur_irq = irq;
    irq_i = irq; reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    c_pend = irq & 16'h3FFE;
    if (we) begin
      n = int'(a[3:0]);
      if (a == 6'h01) c_mask = d;
      else if (a[5:4] == 2'b01 && n >= 1 && n <= 13) c_ctrl[n] = d[7:0];
      else if (a[5:4] == 2'b10 && (n == 12 || n == 13)) c_vec[n] = d[7:0];
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d); step(cur_irq, 1'b1, a, d); endtask
  task automatic idle(); step(cur_irq, 1'b0, 6'h00, 16'h0); endtask
  task automatic setirq(input logic [15:0] x); step(x, 1'b0, 6'h00, 16'h0); endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    reg_addr_i = a;
    #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic out_chk(input logic [2:0] lvl, input logic [7:0] vec, input string tag);
    chk(tag, {5'b0, irq_level_o, irq_vector_o}, {5'b0, lvl, vec});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cur_irq = '0;
    c_pend = '0; c_mask = 16'hFFFF; c_ctrl = '0; c_vec = '0;
    c_vec[12] = 8'h0F; c_vec[13] = 8'h0F;
    p_pend = c_pend; p_mask = c_mask; p_ctrl = c_ctrl; p_vec = c_vec;
    repeat (2) @(negedge clk_i);
    #2 rst_ni = 1'b1;

    idle();
    rd(6'h01, 16'hFFFF, "R10 mask reset");
    rd(6'h15, 16'h0000, "R10 ctrl reset");
    rd(6'h2C, 16'h000F, "R10 uart vector reset");
    rd(6'h25, 16'h0000, "R10 non-uart vector");
    rd(6'h00, 16'h0000, "R1 pending reset");
    out_chk(3'd0, 8'h00, "R7 reset outputs");

    // bit 0 has no effect
    setirq(16'h0001); wr(6'h01, 16'h0000); idle(); idle();
    rd(6'h00, 16'h0000, "R2 pending bit0");
    out_chk(3'd0, 8'h00, "R2 bit0 no level");

    // zero priority field never wins
    wr(6'h13, 16'h0000); setirq(16'h0008); idle(); idle();
    out_chk(3'd0, 8'h00, "R4 zero field");
    rd(6'h00, 16'h0008, "R1 pending set");

    // tie between uart sources
    wr(6'h2C, 16'h0040); wr(6'h2D, 16'h0041); wr(6'h1C, 16'h000C); wr(6'h1D, 16'h000C);
    setirq(16'h3000); idle(); idle();
    out_chk(3'd3, 8'h40, "R5 tie lowest wins");

    // latency and higher field
    wr(6'h1D, 16'h000D); idle();
    out_chk(3'd3, 8'h40, "R9 output held one edge");
    idle();
    out_chk(3'd3, 8'h41, "R4 larger field wins");

    wr(6'h01, 16'h2000); idle(); idle();
    out_chk(3'd3, 8'h40, "R3 masked source");

    // upper control bits ignored
    wr(6'h12, 16'h000D); wr(6'h1C, 16'h00EC); setirq(16'h1004); idle(); idle();
    out_chk(3'd3, 8'd27, "R11 upper bits ignored");
    rd(6'h1C, 16'h00EC, "R11 upper bits stored");

    wr(6'h12, 16'h001F); idle(); idle();
    out_chk(3'd7, 8'd31, "R6 R8 level and autovector");

    wr(6'h01, 16'hFFFF); idle(); idle();
    out_chk(3'd0, 8'h00, "R7 all masked");

    setirq(16'h5A5B); idle();
    rd(6'h00, 16'h1A5A, "R1 R2 pending pattern");
    setirq(16'h0000); idle();
    rd(6'h00, 16'h0000, "R1 pending clears");

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] irq;
      int          kind;
      irq  = 16'($urandom);
      kind = int'($urandom % 8);
      if ($urandom % 3 == 0) begin
        if (kind == 0)      step(irq, 1'b1, 6'h01, 16'($urandom) & 16'($urandom));
        else if (kind < 6)  step(irq, 1'b1, {2'b01, 4'($urandom)}, 16'($urandom));
        else                step(irq, 1'b1, {2'b10, 4'($urandom)}, 16'($urandom));
      end else begin
        step(irq, 1'b0, 6'h00, 16'h0);
      end
    end
    idle(); idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule